// File: doc/BRIEF.md
# I/Q Sample RAM Test Access Port

This block lets a host read and write the sample storage of four filter channels by indirect address, but only while a test-mode input is high. Each channel keeps 24-bit sample pairs in two banks. Every pair has an in-phase half and a quadrature half, and the two halves sit at neighbouring addresses. The block decodes each 16-bit host address into a channel, a bank, a pair index and a Q/I selector. Addresses in the holes of the map are refused.

Writes follow a two-step protocol. A Q word waits in a staging register. The I word that completes the same pair then writes both halves into storage in one clock. An I word that does not complete the staged pair is dropped and raises a sticky error flag. Reads may target any valid word in any order. Read data is registered and appears one clock after the strobe. When test mode falls, the channels go back to normal use and a pending Q word is lost.

Top module: `iq_test_ram_port`

## Requirements
- R1: While `rst_ni` is low, `rdata_o` is 0 and `seq_err_o` is 0. A reset also clears a set error flag.
- R2: `addr_i[15:12]` selects the channel, values 0 to 3. `addr_i[11:0]` is the offset within that channel. Valid offsets are 0x000-0x2FF (bank 0) and 0x400-0x6FF (bank 1). Pair n of a bank has its Q word at even offset 2n and its I word at odd offset 2n+1. The two banks hold different storage.
- R3: A write to an even valid offset only stages the Q word, so storage is unchanged. The next I write to the odd offset of the same channel and pair stores both words in the same clock.
- R4: An odd-offset write is discarded when no Q word is staged, or when the staged Q belongs to another channel or pair. The discard sets `seq_err_o` and drops the staged word. `seq_err_o` then stays high until reset. Even-offset writes never set it.
- R5: A read strobe loads `rdata_o` at the next rising edge. Valid words can be read in any order and return the stored value.
- R6: A read returns 0 when test mode is off, when the channel field is above 3, or when the offset is 0x300-0x3FF or 0x700-0xFFF.
- R7: A write under any of the conditions in R6 is ignored. It changes no storage, no staged word and no error flag.
- R8: `rdata_o` changes only on a clock edge where `rd_i` is high.
- R9: A second Q write before the closing I write replaces the staged word, including its channel and pair.
- R10: Dropping test mode discards a staged Q word. A later I write for that pair is then handled as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | High enables host access to the sample storage |
| wr_i | input | 1 | Write strobe, one word per cycle |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 16 | Indirect address: channel in [15:12], offset in [11:0] |
| wdata_i | input | 24 | Write word |
| rdata_o | output | 24 | Registered read word |
| seq_err_o | output | 1 | Sticky pair-sequence error |

## Verification
Read data and the error flag both settle one clock after their strobe. The bench raises each strobe on a falling edge and lowers it on the next falling edge, and it samples results only at that second falling edge, half a cycle after the registering edge. Stored contents take effect on the edge that takes the closing I word. Every storage check is therefore a read issued after that edge, with its result due one clock later. Ignored writes and discarded pairs are checked by reading back the addresses a faulty decoder would alias to.

// File: rtl/iq_ram_pkg.sv
`timescale 1ns/1ps
package iq_ram_pkg;
  localparam int unsigned NUM_CH         = 4;
  localparam int unsigned DATA_W         = 24;
  localparam int unsigned ADDR_W         = 16;
  localparam int unsigned OFF_W          = 12;
  localparam int unsigned PAIRS_PER_BANK = 384;
  localparam int unsigned CH_W           = ADDR_W - OFF_W;
  localparam int unsigned PAIR_IDX_W     = $clog2(2 * PAIRS_PER_BANK);

  typedef struct packed {
    logic                  valid;
    logic [CH_W-1:0]       ch;
    logic [PAIR_IDX_W-1:0] pair;
    logic                  is_i;
  } iq_dec_t;
endpackage

// File: rtl/iq_addr_decode.sv
`timescale 1ns/1ps
module iq_addr_decode
  import iq_ram_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output iq_dec_t           dec_o
);
  // offset layout: [OFF_W-1] above both banks, [OFF_W-2] bank, [OFF_W-3:1] word pair, [0] Q/I
  localparam int unsigned WPAIR_W = OFF_W - 3;
  localparam logic [WPAIR_W-1:0]    PPB_W   = WPAIR_W'(PAIRS_PER_BANK);
  localparam logic [PAIR_IDX_W-1:0] PPB_P   = PAIR_IDX_W'(PAIRS_PER_BANK);
  localparam logic [CH_W-1:0]       NCH_L   = CH_W'(NUM_CH);

  logic [OFF_W-1:0]   off;
  logic [WPAIR_W-1:0] wpair;
  logic               bank;
  logic               above;

  always_comb begin
    off   = addr_i[OFF_W-1:0];
    above = off[OFF_W-1];
    bank  = off[OFF_W-2];
    wpair = off[OFF_W-3:1];
    dec_o.ch    = addr_i[ADDR_W-1:OFF_W];
    dec_o.is_i  = off[0];
    dec_o.pair  = PAIR_IDX_W'(wpair) + (bank ? PPB_P : '0);
    dec_o.valid = (dec_o.ch < NCH_L) && !above && (wpair < PPB_W);
  end
endmodule

// File: rtl/iq_pair_stager.sv
`timescale 1ns/1ps
module iq_pair_stager
  import iq_ram_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  test_mode_i,
  input  logic                  wr_en_i,
  input  iq_dec_t               dec_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  commit_o,
  output logic [CH_W-1:0]       commit_ch_o,
  output logic [PAIR_IDX_W-1:0] commit_pair_o,
  output logic [DATA_W-1:0]     commit_q_o,
  output logic                  seq_err_o
);
  logic                  stg_v_q, stg_v_d;
  logic                  err_q, err_d;
  logic                  load_en;
  logic [CH_W-1:0]       stg_ch_q;
  logic [PAIR_IDX_W-1:0] stg_pair_q;
  logic [DATA_W-1:0]     stg_word_q;

  always_comb begin
    stg_v_d  = stg_v_q;
    err_d    = err_q;
    load_en  = 1'b0;
    commit_o = 1'b0;
    if (!test_mode_i) begin
      stg_v_d = 1'b0;
    end else if (wr_en_i) begin
      if (!dec_i.is_i) begin
        stg_v_d = 1'b1;
        load_en = 1'b1;
      end else begin
        stg_v_d = 1'b0;
        if (stg_v_q && (stg_ch_q == dec_i.ch) && (stg_pair_q == dec_i.pair))
          commit_o = 1'b1;
        else
          err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stg_v_q <= stg_v_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_en) begin
      stg_ch_q   <= dec_i.ch;
      stg_pair_q <= dec_i.pair;
      stg_word_q <= wdata_i;
    end
  end

  assign commit_ch_o   = stg_ch_q;
  assign commit_pair_o = stg_pair_q;
  assign commit_q_o    = stg_word_q;
  assign seq_err_o     = err_q;
endmodule

// File: rtl/iq_chan_ram.sv
`timescale 1ns/1ps
module iq_chan_ram #(
  parameter int unsigned DEPTH  = 768,
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [WIDTH-1:0] wq_i,
  input  logic [WIDTH-1:0] wi_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [WIDTH-1:0] rq_o,
  output logic [WIDTH-1:0] ri_o
);
  logic [WIDTH-1:0] q_mem [DEPTH];
  logic [WIDTH-1:0] i_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      q_mem[widx_i] <= wq_i;
      i_mem[widx_i] <= wi_i;
    end
  end

  assign rq_o = q_mem[ridx_i];
  assign ri_o = i_mem[ridx_i];
endmodule

// File: rtl/iq_test_ram_port.sv
`timescale 1ns/1ps
module iq_test_ram_port
  import iq_ram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_mode_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [15:0]       addr_i,
  input  logic [23:0]       wdata_i,
  output logic [23:0]       rdata_o,
  output logic              seq_err_o
);
  localparam int unsigned DEPTH    = 2 * PAIRS_PER_BANK;
  localparam int unsigned CH_SEL_W = $clog2(NUM_CH);

  iq_dec_t               dec;
  logic                  wr_en;
  logic                  rd_ok;
  logic                  commit;
  logic [CH_W-1:0]       commit_ch;
  logic [PAIR_IDX_W-1:0] commit_pair;
  logic [DATA_W-1:0]     commit_q;
  logic [DATA_W-1:0]     rq [NUM_CH];
  logic [DATA_W-1:0]     ri [NUM_CH];
  logic [DATA_W-1:0]     rdata_d, rdata_q;

  iq_addr_decode i_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  assign wr_en = wr_i && test_mode_i && dec.valid;
  assign rd_ok = rd_i && test_mode_i && dec.valid;

  iq_pair_stager i_stager (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .test_mode_i   (test_mode_i),
    .wr_en_i       (wr_en),
    .dec_i         (dec),
    .wdata_i       (wdata_i),
    .commit_o      (commit),
    .commit_ch_o   (commit_ch),
    .commit_pair_o (commit_pair),
    .commit_q_o    (commit_q),
    .seq_err_o     (seq_err_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic we_c;
    assign we_c = commit && (commit_ch == CH_W'(c));
    iq_chan_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W), .IDX_W(PAIR_IDX_W)) i_ram (
      .clk_i  (clk_i),
      .we_i   (we_c),
      .widx_i (commit_pair),
      .wq_i   (commit_q),
      .wi_i   (wdata_i),
      .ridx_i (dec.pair),
      .rq_o   (rq[c]),
      .ri_o   (ri[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (rd_ok)
      rdata_d = dec.is_i ? ri[dec.ch[CH_SEL_W-1:0]] : rq[dec.ch[CH_SEL_W-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/iq_test_ram_port_chk.sv
`timescale 1ns/1ps
module iq_test_ram_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        test_mode_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [15:0] addr_i,
  input logic [23:0] wdata_i,
  input logic [23:0] rdata_o,
  input logic        seq_err_o
);
  logic [11:0] off;
  logic        in_map;
  assign off    = addr_i[11:0];
  assign in_map = test_mode_i && (addr_i[15:12] < 4'd4) &&
                  ((off < 12'h300) || ((off >= 12'h400) && (off < 12'h700)));

  // R6: refused reads return zero
  a_r6_refused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_map) |=> (rdata_o == 24'd0));

  // R8: output only moves under a read strobe
  a_r8_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R4: error flag is sticky
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);

  // R7: ignored writes leave the flag alone
  a_r7_ignored_write_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !in_map) |=> $stable(seq_err_o));

  // R3: Q writes only stage and never flag an error
  a_r3_q_write_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i[0]) |=> $stable(seq_err_o));

  // R4: without any write the flag cannot rise
  a_r4_no_write_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(seq_err_o));
endmodule

bind iq_test_ram_port iq_test_ram_port_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .test_mode_i (test_mode_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .seq_err_o   (seq_err_o)
);

// File: tb/test_iq_test_ram_port.sv
`timescale 1ns/1ps
module test_iq_test_ram_port;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        test_mode;
  logic        wr, rd;
  logic [15:0] addr;
  logic [23:0] wdata;
  logic [23:0] rdata;
  logic        seq_err;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  iq_test_ram_port i_iq_test_ram_port (
    .clk_i (clk), .rst_ni (rst_ni), .test_mode_i (test_mode),
    .wr_i (wr), .rd_i (rd), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .seq_err_o (seq_err)
  );

  function automatic logic [23:0] pat(input int ch, input int off, input int salt);
    return 24'(ch * 24'h010101 + off * 13 + salt * 24'h0005a5 + 1);
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_word(input logic [15:0] a, input logic [23:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_word(input logic [15:0] a, output logic [23:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wr_pair(input int ch, input int off, input logic [23:0] q, input logic [23:0] i);
    wr_word(16'(ch * 4096 + off), q);
    wr_word(16'(ch * 4096 + off + 1), i);
  endtask

  task automatic rd_check(input string req, input int ch, input int off, input logic [23:0] exp);
    logic [23:0] d;
    rd_word(16'(ch * 4096 + off), d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 24'd0);
    check("R1 seq_err", 24'(seq_err), 24'd0);
  endtask

  // R2 R3 R5: pairs in all channels and both banks, read back in reverse order
  task automatic t_pairs;
    int offs[5] = '{'h000, 'h022, 'h2FE, 'h400, 'h6FE};
    for (int c = 0; c < 4; c++)
      foreach (offs[k]) wr_pair(c, offs[k], pat(c, offs[k], 0), pat(c, offs[k] + 1, 0));
    for (int c = 3; c >= 0; c--)
      for (int k = 4; k >= 0; k--) begin
        rd_check("R5 I word", c, offs[k] + 1, pat(c, offs[k] + 1, 0));
        rd_check("R2 Q word", c, offs[k], pat(c, offs[k], 0));
      end
    check("R3 no error on good pairs", 24'(seq_err), 24'd0);
  endtask

  // R3: staged Q invisible until its I arrives
  task automatic t_staged;
    wr_word(16'h1022, 24'hABCDEF);
    rd_check("R3 Q not yet stored", 1, 'h022, pat(1, 'h022, 0));
    wr_word(16'h1023, 24'h123456);
    rd_check("R3 Q stored with I", 1, 'h022, 24'hABCDEF);
    rd_check("R3 I stored", 1, 'h023, 24'h123456);
  endtask

  // R6 R7: holes and bad channels
  task automatic t_holes;
    rd_check("R6 read before hole", 0, 'h400, pat(0, 'h400, 0));
    rd_check("R6 hole 0x300", 0, 'h300, 24'd0);
    rd_check("R6 hole 0x7FE", 0, 'h7FE, 24'd0);
    rd_check("R6 hole 0x800", 2, 'h800, 24'd0);
    rd_check("R6 channel 4", 4, 'h000, 24'd0);
    wr_pair(0, 'h300, 24'h111111, 24'h222222);
    wr_pair(4, 'h000, 24'h333333, 24'h444444);
    wr_pair(0, 'h800, 24'h555555, 24'h666666);
    rd_check("R7 bank1 untouched", 0, 'h400, pat(0, 'h400, 0));
    rd_check("R7 ch0 untouched", 0, 'h000, pat(0, 'h000, 0));
    rd_check("R7 ch0 I untouched", 0, 'h001, pat(0, 'h001, 0));
    check("R7 no error from ignored writes", 24'(seq_err), 24'd0);
    // R7: an ignored write does not disturb a staged Q
    wr_word(16'h2022, 24'h0F0F0F);
    wr_word(16'h2301, 24'h777777);
    wr_word(16'h2023, 24'h070707);
    rd_check("R7 staging kept", 2, 'h022, 24'h0F0F0F);
    check("R7 staging kept no error", 24'(seq_err), 24'd0);
  endtask

  // R8: output holds without a read strobe
  task automatic t_hold;
    logic [23:0] d;
    rd_word(16'h3400, d);
    check("R8 read value", d, pat(3, 'h400, 0));
    wr_pair(3, 'h100, 24'h010203, 24'h040506);
    @(negedge clk);
    @(negedge clk);
    check("R8 rdata held", rdata, pat(3, 'h400, 0));
  endtask

  // R9: later Q replaces staged Q
  task automatic t_replace;
    wr_word(16'h0022, 24'hAAAAAA);
    wr_word(16'h0022, 24'hBBBBBB);
    wr_word(16'h0023, 24'hCCCCCC);
    rd_check("R9 second Q kept", 0, 'h022, 24'hBBBBBB);
    wr_word(16'h0400, 24'hDDDDDD);
    wr_word(16'h1400, 24'hEEEEEE);
    wr_word(16'h1401, 24'hFFFFFF);
    rd_check("R9 first pair untouched", 0, 'h400, pat(0, 'h400, 0));
    rd_check("R9 new pair Q", 1, 'h400, 24'hEEEEEE);
    check("R9 no error", 24'(seq_err), 24'd0);
  endtask

  // R6 R7 R10: test mode off
  task automatic t_testoff;
    test_mode = 1'b0;
    rd_check("R6 test off read", 2, 'h2FE, 24'd0);
    wr_pair(2, 'h2FE, 24'h999999, 24'h888888);
    test_mode = 1'b1;
    rd_check("R7 test off write ignored", 2, 'h2FE, pat(2, 'h2FE, 0));
    check("R7 test off no error", 24'(seq_err), 24'd0);
    wr_word(16'h32FE, 24'h121212);
    test_mode = 1'b0;
    @(negedge clk);
    test_mode = 1'b1;
    wr_word(16'h32FF, 24'h343434);
    rd_check("R10 staged Q dropped", 3, 'h2FE, pat(3, 'h2FE, 0));
    rd_check("R10 I dropped", 3, 'h2FF, pat(3, 'h2FF, 0));
    check("R10 error raised", 24'(seq_err), 24'd1);
  endtask

  // R4: mismatched and lone I writes
  task automatic t_seqerr;
    wr_word(16'h0000, 24'h5A5A5A);
    wr_word(16'h0023, 24'h6B6B6B);
    wr_word(16'h0001, 24'h7C7C7C);
    rd_check("R4 wrong pair discarded", 0, 'h023, 24'hCCCCCC);
    rd_check("R4 staged Q dropped", 0, 'h000, pat(0, 'h000, 0));
    rd_check("R4 lone I discarded", 0, 'h001, pat(0, 'h001, 0));
    repeat (5) @(negedge clk);
    check("R4 error sticky", 24'(seq_err), 24'd1);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset clears error", 24'(seq_err), 24'd0);
    check("R1 reset clears rdata", rdata, 24'd0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 1'b0; test_mode = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_mode = 1'b1;
    t_pairs();
    t_staged();
    t_holes();
    t_hold();
    t_replace();
    t_testoff();
    t_seqerr();
    summary();
  end
endmodule